// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the line and frame timing for a display pipe from a pixel clock. A horizontal counter runs across each line and a vertical counter steps once per line. Every boundary in the raster is a programmable absolute counter position. These boundaries are sync end, blank end, start and end of the addressable area, and blank start. Position zero of both counters is the leading edge of sync, so the sync pulse, the back porch, the left border, the addressable pixels, the right border and the front porch follow one another in that order. From the counters the block derives the sync strobes with selectable polarity, the blank flags, a data-enable and a border flag.

An output mux picks one of four sources for each pixel: the incoming pixel word, an overscan colour for the border bands, a black colour during normal blanking, or a fill colour that replaces every pixel while forced blanking is on. Software programs the block through a single-cycle write port and observes it through a combinational read port. The read port returns the programmed settings, the live position, a frame counter, the vertical-blank flag and a timing-error flag. Timing settings are double-buffered and take effect at the end of a frame, so a write made while the raster is running does not tear the current frame.

Top module: `raster_tgen`

## Requirements
- R1: While running, the horizontal counter steps by one per clock from 0 up to the programmed horizontal total (line length minus one) and then returns to 0. The vertical counter steps by one on each horizontal return and goes back to 0 after it reaches the vertical total.
- R2: A sync strobe is in its active state while its counter is below the sync-end position. Control bit 1 (horizontal) or bit 2 (vertical) at 0 makes the active state high, and at 1 makes it low.
- R3: On each axis the blank flag is set below the blank-end position and at or above the blank-start position. The active flag is set from the active-start position up to, but not including, the active-end position. Data-enable is high only when both axes are active and neither axis is blanked. The border flag is high when neither axis is blanked and data-enable is low.
- R4: Outside blanking, pixels in the border bands carry the overscan colour and addressable pixels carry the input word. Every colour word holds B/Cb in the low component, G/Y in the middle component and R/Cr in the high component.
- R5: During blanking the output carries the black colour. While control bit 3 is set, every output pixel carries the fill colour, whatever the position.
- R6: Control bit 0 runs the counters. While it is clear, the position and the frame counter hold their values.
- R7: The frame counter increments by one on the clock where the vertical counter enters the vertical blank-start line, and at no other time.
- R8: While running, the timing settings in use change only on the clock that wraps both counters. While stopped, newly written settings take effect on the next clock.
- R9: The error flag (read address 18, bit 1) is set when the programmed horizontal blank (total+1−blank start+blank end) is under 56 clocks, when the front porch (total+1−blank start) is under 4, or when the back porch (blank end−sync end) is under 4. The arithmetic is unsigned and two bits wider than the counters.
- R10: Read addresses: 0 control; 1–6 horizontal total, sync end, blank end, active start, active end, blank start (the written values); 7–12 the same for vertical; 13 overscan, 14 black and 15 fill colour; 16 position {vertical, horizontal}; 17 frame counter; 18 {error, vertical blank}. Any other address reads zero.
- R11: Control bit 4 (interlace) is stored and read back, and has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 24 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 24 | Read data, combinational |
| pix_in | input | 24 | Incoming pixel word |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| hblank | output | 1 | Horizontal blank flag |
| vblank | output | 1 | Vertical blank flag |
| de | output | 1 | Data-enable, addressable area only |
| border | output | 1 | Overscan band flag |
| pix_out | output | 24 | Muxed output pixel |
| h_pos | output | 12 | Live horizontal count |
| v_pos | output | 12 | Live vertical count |
| frame_cnt | output | 16 | Frame counter |
| timing_err | output | 1 | Programmed timing violates the limits |

## Verification
Assertions check four things on every cycle: the single-step advance of the horizontal counter, that both counters and the frame counter freeze while stopped, that the frame counter changes only at line start and only by one, and that the timing set in use stays fixed between frame wraps while running. They also check that forced fill and blanking pick the right colour source. Only the bench scenarios can show the sync pulse placement under each polarity, the border and data-enable windows, the tear-free effect of a mid-frame write of the line length, the readback map, and each of the three timing-error causes.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   // field index inside one axis timing set
   localparam int AX_TOTAL       = 0;
   localparam int AX_SYNC_END    = 1;
   localparam int AX_BLANK_END   = 2;
   localparam int AX_ACT_START   = 3;
   localparam int AX_ACT_END     = 4;
   localparam int AX_BLANK_START = 5;
   localparam int AX_FIELDS      = 6;

   localparam int ADDR_W = 5;

   typedef enum logic [ADDR_W-1:0] {
      RA_CTRL      = 5'd0,
      RA_H_BASE    = 5'd1,
      RA_V_BASE    = 5'd7,
      RA_OVS_COL   = 5'd13,
      RA_BLACK_COL = 5'd14,
      RA_FILL_COL  = 5'd15,
      RA_POS       = 5'd16,
      RA_FRAMES    = 5'd17,
      RA_FLAGS     = 5'd18
   } reg_addr_e;

   // control bits
   localparam int CB_RUN   = 0;
   localparam int CB_HPOL  = 1;
   localparam int CB_VPOL  = 2;
   localparam int CB_FILL  = 3;
   localparam int CB_ILACE = 4;
   localparam int CTRL_W   = 5;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
   import rtg_pkg::*;
#(
   parameter int CNT_W  = 12,
   parameter int PIX_W  = 24,
   parameter int DATA_W = 24
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [ADDR_W-1:0]                  wr_addr,
   input  logic [DATA_W-1:0]                  wr_data,
   input  logic                               frame_end,
   output logic [CTRL_W-1:0]                  ctrl,
   output logic [AX_FIELDS-1:0][CNT_W-1:0]    h_pend,
   output logic [AX_FIELDS-1:0][CNT_W-1:0]    v_pend,
   output logic [AX_FIELDS-1:0][CNT_W-1:0]    h_act,
   output logic [AX_FIELDS-1:0][CNT_W-1:0]    v_act,
   output logic [PIX_W-1:0]                   ovs_col,
   output logic [PIX_W-1:0]                   black_col,
   output logic [PIX_W-1:0]                   fill_col
);
   // stopped raster takes new timing at once, running raster only at the frame wrap
   logic load;
   assign load = !ctrl[CB_RUN] || frame_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl      <= '0;
         h_pend    <= '0;
         v_pend    <= '0;
         h_act     <= '0;
         v_act     <= '0;
         ovs_col   <= '0;
         black_col <= '0;
         fill_col  <= '0;
      end else begin
         if (load) begin
            h_act <= h_pend;
            v_act <= v_pend;
         end
         if (wr_en) begin
            if (wr_addr == RA_CTRL)      ctrl      <= wr_data[CTRL_W-1:0];
            if (wr_addr == RA_OVS_COL)   ovs_col   <= wr_data[PIX_W-1:0];
            if (wr_addr == RA_BLACK_COL) black_col <= wr_data[PIX_W-1:0];
            if (wr_addr == RA_FILL_COL)  fill_col  <= wr_data[PIX_W-1:0];
            for (int i = 0; i < AX_FIELDS; i++) begin
               if (int'(wr_addr) == int'(RA_H_BASE) + i) h_pend[i] <= wr_data[CNT_W-1:0];
               if (int'(wr_addr) == int'(RA_V_BASE) + i) v_pend[i] <= wr_data[CNT_W-1:0];
            end
         end
      end
   end

   // R8: the timing in use is frozen mid-frame while running
   p_active_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[CB_RUN] && !frame_end) |=> ($stable(h_act) && $stable(v_act)));
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters #(
   parameter int CNT_W   = 12,
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [CNT_W-1:0]   h_total,
   input  logic [CNT_W-1:0]   v_total,
   input  logic [CNT_W-1:0]   v_blank_start,
   output logic [CNT_W-1:0]   h_cnt,
   output logic [CNT_W-1:0]   v_cnt,
   output logic [FRAME_W-1:0] frames,
   output logic               frame_end
);
   logic             h_wrap, v_wrap;
   logic [CNT_W-1:0] v_next;

   // >= so that a shortened total never strands the counter above it
   assign h_wrap    = h_cnt >= h_total;
   assign v_wrap    = v_cnt >= v_total;
   assign v_next    = v_wrap ? '0 : v_cnt + 1'b1;
   assign frame_end = run && h_wrap && v_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_cnt  <= '0;
         v_cnt  <= '0;
         frames <= '0;
      end else if (run) begin
         if (h_wrap) begin
            h_cnt <= '0;
            v_cnt <= v_next;
            if (v_next == v_blank_start) frames <= frames + 1'b1;
         end else begin
            h_cnt <= h_cnt + 1'b1;
         end
      end
   end

   p_h_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !h_wrap) |=> (h_cnt == $past(h_cnt) + 1'b1) && $stable(v_cnt));
   p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ($stable(h_cnt) && $stable(v_cnt) && $stable(frames)));
   p_frame_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(frames) |-> ((h_cnt == '0) && (frames == $past(frames) + 1'b1)));
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
   import rtg_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic [CNT_W-1:0]                pos,
   input  logic [AX_FIELDS-1:0][CNT_W-1:0] cfg,
   output logic                            sync_on,
   output logic                            blank,
   output logic                            active
);
   assign sync_on = pos < cfg[AX_SYNC_END];
   assign blank   = (pos < cfg[AX_BLANK_END]) || (pos >= cfg[AX_BLANK_START]);
   assign active  = (pos >= cfg[AX_ACT_START]) && (pos < cfg[AX_ACT_END]);
endmodule

// File: rtl/rtg_pixmux.sv
module rtg_pixmux #(
   parameter int COMP_W = 8,
   parameter int NCOMP  = 3
) (
   input  logic                    fill_en,
   input  logic                    blank,
   input  logic                    border,
   input  logic [NCOMP*COMP_W-1:0] pix_in,
   input  logic [NCOMP*COMP_W-1:0] ovs_col,
   input  logic [NCOMP*COMP_W-1:0] black_col,
   input  logic [NCOMP*COMP_W-1:0] fill_col,
   output logic [NCOMP*COMP_W-1:0] pix_out
);
   // one selector per colour component, low component is B/Cb
   for (genvar c = 0; c < NCOMP; c++) begin : g_comp
      assign pix_out[c*COMP_W +: COMP_W] =
         fill_en ? fill_col[c*COMP_W +: COMP_W]  :
         blank   ? black_col[c*COMP_W +: COMP_W] :
         border  ? ovs_col[c*COMP_W +: COMP_W]   :
                   pix_in[c*COMP_W +: COMP_W];
   end
endmodule

// File: rtl/raster_tgen.sv
module raster_tgen
   import rtg_pkg::*;
#(
   parameter int CNT_W      = 12,
   parameter int COMP_W     = 8,
   parameter int FRAME_W    = 16,
   parameter int MIN_HBLANK = 56,
   parameter int MIN_PORCH  = 4,
   localparam int PIX_W     = 3 * COMP_W,
   localparam int DATA_W    = (PIX_W > 2*CNT_W) ? ((PIX_W > FRAME_W) ? PIX_W : FRAME_W)
                                                : ((2*CNT_W > FRAME_W) ? 2*CNT_W : FRAME_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [DATA_W-1:0]   rd_data,
   input  logic [PIX_W-1:0]    pix_in,
   output logic                hsync,
   output logic                vsync,
   output logic                hblank,
   output logic                vblank,
   output logic                de,
   output logic                border,
   output logic [PIX_W-1:0]    pix_out,
   output logic [CNT_W-1:0]    h_pos,
   output logic [CNT_W-1:0]    v_pos,
   output logic [FRAME_W-1:0]  frame_cnt,
   output logic                timing_err
);
   localparam int EW = CNT_W + 2;

   if (CNT_W < 4 || CNT_W > 16) begin : g_bad_cnt
      $error("raster_tgen: CNT_W out of range");
   end
   if (COMP_W < 1) begin : g_bad_comp
      $error("raster_tgen: COMP_W must be positive");
   end
   if (MIN_HBLANK >= (1 << CNT_W)) begin : g_bad_hblank
      $error("raster_tgen: MIN_HBLANK exceeds counter range");
   end

   logic [CTRL_W-1:0]               ctrl;
   logic [AX_FIELDS-1:0][CNT_W-1:0] h_pend, v_pend, h_act, v_act;
   logic [PIX_W-1:0]                ovs_col, black_col, fill_col;
   logic                            frame_end;
   logic                            h_sync_on, v_sync_on, h_blank, v_blank, h_in, v_in;
   logic                            any_blank;

   rtg_regs #(.CNT_W(CNT_W), .PIX_W(PIX_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .frame_end(frame_end), .ctrl(ctrl), .h_pend(h_pend), .v_pend(v_pend),
      .h_act(h_act), .v_act(v_act), .ovs_col(ovs_col), .black_col(black_col),
      .fill_col(fill_col)
   );

   rtg_counters #(.CNT_W(CNT_W), .FRAME_W(FRAME_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(ctrl[CB_RUN]),
      .h_total(h_act[AX_TOTAL]), .v_total(v_act[AX_TOTAL]),
      .v_blank_start(v_act[AX_BLANK_START]),
      .h_cnt(h_pos), .v_cnt(v_pos), .frames(frame_cnt), .frame_end(frame_end)
   );

   rtg_axis #(.CNT_W(CNT_W)) u_h_axis (
      .pos(h_pos), .cfg(h_act), .sync_on(h_sync_on), .blank(h_blank), .active(h_in));
   rtg_axis #(.CNT_W(CNT_W)) u_v_axis (
      .pos(v_pos), .cfg(v_act), .sync_on(v_sync_on), .blank(v_blank), .active(v_in));

   assign any_blank = h_blank || v_blank;
   assign hsync     = h_sync_on ^ ctrl[CB_HPOL];
   assign vsync     = v_sync_on ^ ctrl[CB_VPOL];
   assign hblank    = h_blank;
   assign vblank    = v_blank;
   assign de        = h_in && v_in && !any_blank;
   assign border    = !any_blank && !(h_in && v_in);

   rtg_pixmux #(.COMP_W(COMP_W), .NCOMP(3)) u_mux (
      .fill_en(ctrl[CB_FILL]), .blank(any_blank), .border(border), .pix_in(pix_in),
      .ovs_col(ovs_col), .black_col(black_col), .fill_col(fill_col), .pix_out(pix_out));

   // sanity check of the programmed (not yet active) horizontal timing
   logic [EW-1:0] h_len, h_fp, h_blank_len, h_bp;
   logic          porch_err;
   assign h_len       = EW'(h_pend[AX_TOTAL]) + 1'b1;
   assign h_fp        = h_len - EW'(h_pend[AX_BLANK_START]);
   assign h_blank_len = h_fp + EW'(h_pend[AX_BLANK_END]);
   assign h_bp        = EW'(h_pend[AX_BLANK_END]) - EW'(h_pend[AX_SYNC_END]);

   if (MIN_PORCH > 0) begin : g_porch_chk
      assign porch_err = (h_fp < EW'(MIN_PORCH)) || (h_bp < EW'(MIN_PORCH));
   end else begin : g_porch_off
      assign porch_err = 1'b0;
   end
   assign timing_err = (h_blank_len < EW'(MIN_HBLANK)) || porch_err;

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < AX_FIELDS; i++) begin
         if (int'(rd_addr) == int'(RA_H_BASE) + i) rd_data[CNT_W-1:0] = h_pend[i];
         if (int'(rd_addr) == int'(RA_V_BASE) + i) rd_data[CNT_W-1:0] = v_pend[i];
      end
      case (rd_addr)
         RA_CTRL:      rd_data[CTRL_W-1:0]  = ctrl;
         RA_OVS_COL:   rd_data[PIX_W-1:0]   = ovs_col;
         RA_BLACK_COL: rd_data[PIX_W-1:0]   = black_col;
         RA_FILL_COL:  rd_data[PIX_W-1:0]   = fill_col;
         RA_POS:       rd_data[2*CNT_W-1:0] = {v_pos, h_pos};
         RA_FRAMES:    rd_data[FRAME_W-1:0] = frame_cnt;
         RA_FLAGS:     rd_data[1:0]         = {timing_err, v_blank};
         default:      ;
      endcase
   end

   p_fill_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[CB_FILL] |-> (pix_out == fill_col));
   p_blank_black_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[CB_FILL] && (hblank || vblank)) |-> (pix_out == black_col));
   p_de_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> ((h_pos >= h_act[AX_ACT_START]) && (h_pos < h_act[AX_ACT_END])
              && (v_pos >= v_act[AX_ACT_START]) && (v_pos < v_act[AX_ACT_END])));
endmodule

// File: tb/raster_tgen_test.sv
module raster_tgen_test;
   localparam int CNT_W = 12, FRAME_W = 16, PIX_W = 24, DATA_W = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic              wr_en = 1'b0;
   logic [4:0]        wr_addr = '0;
   logic [4:0]        rd_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [PIX_W-1:0]  pix_in = 24'h13579b;
   logic [DATA_W-1:0] rd_data;
   logic              hsync, vsync, hblank, vblank, de, border, timing_err;
   logic [PIX_W-1:0]  pix_out;
   logic [CNT_W-1:0]  h_pos, v_pos;
   logic [FRAME_W-1:0] frame_cnt;

   raster_tgen uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .pix_in(pix_in), .hsync(hsync), .vsync(vsync),
      .hblank(hblank), .vblank(vblank), .de(de), .border(border), .pix_out(pix_out),
      .h_pos(h_pos), .v_pos(v_pos), .frame_cnt(frame_cnt), .timing_err(timing_err));

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- reference model (from the requirements) ----------------
   int m_ctrl, m_ovs, m_blk, m_fill, m_h, m_v, m_fr;
   int m_hp[6], m_vp[6], m_ha[6], m_va[6];

   typedef struct packed {
      logic [11:0] h, v;
      logic        hs, vs, hb, vb, de, bd, err;
      logic [23:0] pix, rd;
      logic [15:0] fr;
      logic [4:0]  ra;
      logic [2:0]  src;   // 0 input, 1 border, 2 black, 3 fill
   } exp_t;
   exp_t q[$];

   function automatic logic model_err();
      int len = m_hp[0] + 1;
      int fp  = (len - m_hp[5]) & 16'h3fff;
      int hbl = (fp + m_hp[2]) & 16'h3fff;
      int bp  = (m_hp[2] - m_hp[1]) & 16'h3fff;
      return (hbl < 56) || (fp < 4) || (bp < 4);
   endfunction

   function automatic exp_t model_out();
      exp_t e;
      logic hb, vb, hi, vi, bl;
      hb = (m_h < m_ha[2]) || (m_h >= m_ha[5]);
      vb = (m_v < m_va[2]) || (m_v >= m_va[5]);
      hi = (m_h >= m_ha[3]) && (m_h < m_ha[4]);
      vi = (m_v >= m_va[3]) && (m_v < m_va[4]);
      bl = hb || vb;
      e.h   = 12'(m_h);
      e.v   = 12'(m_v);
      e.hs  = (m_h < m_ha[1]) ^ m_ctrl[1];
      e.vs  = (m_v < m_va[1]) ^ m_ctrl[2];
      e.hb  = hb;
      e.vb  = vb;
      e.de  = hi && vi && !bl;
      e.bd  = !bl && !(hi && vi);
      e.err = model_err();
      e.fr  = 16'(m_fr);
      e.ra  = rd_addr;
      if (m_ctrl[3])  begin e.pix = 24'(m_fill); e.src = 3; end
      else if (bl)    begin e.pix = 24'(m_blk);  e.src = 2; end
      else if (e.bd)  begin e.pix = 24'(m_ovs);  e.src = 1; end
      else            begin e.pix = pix_in;      e.src = 0; end
      case (int'(rd_addr))
         0:  e.rd = 24'(m_ctrl);
         1, 2, 3, 4, 5, 6:       e.rd = 24'(m_hp[int'(rd_addr) - 1]);
         7, 8, 9, 10, 11, 12:    e.rd = 24'(m_vp[int'(rd_addr) - 7]);
         13: e.rd = 24'(m_ovs);
         14: e.rd = 24'(m_blk);
         15: e.rd = 24'(m_fill);
         16: e.rd = 24'((m_v << 12) | m_h);
         17: e.rd = 24'(m_fr);
         18: e.rd = {22'd0, e.err, vb};
         default: e.rd = '0;
      endcase
      return e;
   endfunction

   // driver side of the scoreboard: advance the model on each edge, push the expectation
   always @(posedge clk) begin
      logic run, hw, vw, fe;
      int   nv;
      if (!rst_n) begin
         m_ctrl = 0; m_ovs = 0; m_blk = 0; m_fill = 0; m_h = 0; m_v = 0; m_fr = 0;
         for (int i = 0; i < 6; i++) begin m_hp[i] = 0; m_vp[i] = 0; m_ha[i] = 0; m_va[i] = 0; end
      end else begin
         run = m_ctrl[0];
         hw  = m_h >= m_ha[0];
         vw  = m_v >= m_va[0];
         nv  = vw ? 0 : m_v + 1;
         fe  = run && hw && vw;
         if (run) begin
            if (hw) begin
               if (nv == m_va[5]) m_fr = (m_fr + 1) % 65536;
               m_v = nv;
               m_h = 0;
            end else m_h = m_h + 1;
         end
         if (!run || fe) begin m_ha = m_hp; m_va = m_vp; end
         if (wr_en) begin
            case (int'(wr_addr))
               0:  m_ctrl = int'(wr_data) & 32'h1f;
               13: m_ovs  = int'(wr_data);
               14: m_blk  = int'(wr_data);
               15: m_fill = int'(wr_data);
               default: begin
                  if (wr_addr >= 1 && wr_addr <= 6)  m_hp[int'(wr_addr) - 1] = int'(wr_data) & 32'hfff;
                  if (wr_addr >= 7 && wr_addr <= 12) m_vp[int'(wr_addr) - 7] = int'(wr_data) & 32'hfff;
               end
            endcase
         end
      end
      q.push_back(model_out());
   end

   // monitor side: pop and compare once the design has settled after the edge
   always @(posedge clk) begin
      exp_t e;
      string ptag, rtag;
      #1;
      if (!done && q.size() > 0) begin
         e = q.pop_front();
         chk("R1 R6 R8", "h_pos", h_pos, e.h);
         chk("R1 R6 R8", "v_pos", v_pos, e.v);
         chk("R2", "hsync", hsync, e.hs);
         chk("R2", "vsync", vsync, e.vs);
         chk("R3", "hblank", hblank, e.hb);
         chk("R3", "vblank", vblank, e.vb);
         chk("R3", "de", de, e.de);
         chk("R3", "border", border, e.bd);
         ptag = (e.src >= 2) ? "R5" : "R4";
         chk(ptag, "pix_out", pix_out, e.pix);
         chk("R7", "frame_cnt", frame_cnt, e.fr);
         chk("R9", "timing_err", timing_err, e.err);
         case (int'(e.ra))
            0:  rtag = "R11";
            17: rtag = "R7";
            18: rtag = "R9";
            default: rtag = "R10";
         endcase
         chk(rtag, $sformatf("rd_data@%0d", e.ra), rd_data, e.rd);
      end
   end

   // stimulus that runs on its own
   always @(negedge clk) begin
      pix_in  <= pix_in + 24'h010307;
      rd_addr <= (rd_addr >= 5'd19) ? 5'd0 : rd_addr + 5'd1;
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 5'(a);
      wr_data = DATA_W'(d);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      int hold_h, hold_v, hold_f;
      idle(3);
      rst_n = 1'b1;
      // reset state: stopped at the origin, no frames counted
      chk("R1", "reset h_pos", h_pos, 0);
      chk("R7", "reset frame_cnt", frame_cnt, 0);
      chk("R10", "reset rd ctrl", uut.rd_addr == 0 ? rd_data : 0, 0);

      // horizontal: 100 clocks, sync 10, back porch 36, borders 4, fp 10
      wr(1, 99); wr(2, 10); wr(3, 46); wr(4, 50); wr(5, 86); wr(6, 90);
      // vertical: 12 lines
      wr(7, 11); wr(8, 2); wr(9, 4); wr(10, 5); wr(11, 9); wr(12, 10);
      wr(13, 24'h20_40_60); wr(14, 24'h01_02_03); wr(15, 24'hf0_e0_d0);
      chk("R9", "legal timing flag", timing_err, 0);

      wr(0, 1);                 // run, active-high syncs
      idle(3000);
      wr(0, 1 | 2);             // R2: active-low hsync
      idle(1300);
      wr(0, 1 | 4);             // R2: active-low vsync
      idle(1300);
      wr(0, 1 | 16);            // R11: interlace bit changes nothing
      idle(1300);
      wr(0, 1 | 8);             // R5: forced fill
      idle(1300);
      wr(0, 1);

      // R8: lengthen the line mid-frame; the current frame keeps the old length
      while (v_pos != 12'd5) @(negedge clk);
      wr(1, 109);
      idle(2700);

      // R6: stop and observe the position holding
      wr(0, 0);
      idle(2);
      hold_h = h_pos; hold_v = v_pos; hold_f = frame_cnt;
      idle(20);
      chk("R6", "stopped h_pos", h_pos, hold_h);
      chk("R6", "stopped v_pos", v_pos, hold_v);
      chk("R6", "stopped frame_cnt", frame_cnt, hold_f);
      wr(0, 1);
      idle(500);
      wr(0, 0);

      // R9: each error cause on its own
      wr(3, 45);                // blank 20+45=... hblank = 110-90+45 = 65? use short blank below
      wr(6, 100);               // fp = 10, hblank = 10+45 = 55 < 56
      chk("R9", "short hblank", timing_err, 1);
      wr(3, 46);                // hblank 56, bp 36
      chk("R9", "hblank at limit", timing_err, 0);
      wr(2, 43);                // bp = 3
      chk("R9", "short back porch", timing_err, 1);
      wr(2, 10);
      wr(3, 60); wr(6, 107);    // fp = 3, hblank 63, bp 50
      chk("R9", "short front porch", timing_err, 1);
      wr(6, 100);
      chk("R9", "porch restored", timing_err, 0);

      wr(0, 1 | 2 | 4);
      idle(1500);
      idle(2);
      finish_run();
   end
endmodule